// File: doc/BRIEF.md
# Dual-Enable Resettable Latch Bank

This block is a bank of level-sensitive D latches, six by default. All of them share one set of controls: two active-low gate inputs and one asynchronous clear. The bank is transparent only while both gate inputs are low. As soon as either gate input goes high, every bit keeps the value it had just before that edge, and it keeps it until both gate inputs are low again. The clear input wins over everything else and drives every stored bit to zero.

Each bit drives two outputs: a true output and its inverse. The block has no clock. It is built from inferred latches with an asynchronous clear, and the enable term is the NOR of the two gate inputs. It is meant to sit where a small control word has to be frozen by either of two independent agents, and that word must have a known zero state.

The latch data path carries no stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `dual_gate_latch_bank`

## Requirements
- R1: The bank holds WIDTH (default 6) independent bits. Bit i of `q_o` depends only on bit i of `d_i` and the shared controls.
- R2: While `clr_i`=0 and both `gate_a_n_i` and `gate_b_n_i` are 0, `q_o` equals `d_i` in the same time step.
- R3: While either gate input is 1, or both are, `q_o` holds its value and changes on `d_i` have no effect.
- R4: The held value is the data present just before the first gate input rose. Raising the second gate input, or dropping one gate input while the other stays high, does not recapture.
- R5: `clr_i`=1 asynchronously forces `q_o` to all zeros, whatever the gate inputs and data are.
- R6: `qb_o` is always the bitwise inverse of `q_o`.
- R7: While `clr_i`=1, `qb_o` is all ones.
- R8: The gate closes when a gate input rises. Data that is stable at least 1.0 ns before that edge is captured. A data change made 0.4 ns or more after that edge is ignored.
- R9: If `clr_i` falls while both gate inputs are low, `q_o` follows `d_i` at once. If `clr_i` falls while the gate is closed, `q_o` stays zero until the gate reopens.
- R10: The usage rules are that `clr_i` stays high for at least 2.0 ns, that the gate stays open for at least 2.0 ns, and that at least 1.6 ns pass between the fall of `clr_i` and the gate closing. A timing monitor checks these rules on the stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_i | input | WIDTH | Data inputs, one per latch |
| gate_a_n_i | input | 1 | First active-low gate input |
| gate_b_n_i | input | 1 | Second active-low gate input |
| clr_i | input | 1 | Asynchronous clear, active high |
| q_o | output | WIDTH | True latch outputs |
| qb_o | output | WIDTH | Complemented latch outputs |

## Verification
The block has no registers between its inputs and its outputs, so every result is due in the same time step as the stimulus that causes it. Transparency, hold, clear and complement all settle with zero clock cycles of delay. The bench therefore drives each stimulus and then waits a fixed 1 to 2 ns before it compares the outputs with its own expected word. The only exception is the capture-window tests, which place the data edge at a stated offset from the gate edge before sampling. A monitor records the time of every data change, gate change and clear change, and so it confirms that each capture met the 1.0 ns setup, 0.4 ns hold, 2.0 ns pulse and 1.6 ns recovery rules.

// File: rtl/dglb_pkg.sv
`timescale 1ns/1ps
package dglb_pkg;
  parameter int unsigned DGLB_WIDTH = 6;

  typedef enum logic [1:0] {
    LB_HOLD  = 2'd0,
    LB_OPEN  = 2'd1,
    LB_CLEAR = 2'd2
  } lb_mode_e;
endpackage

// File: rtl/dglb_gate.sv
`timescale 1ns/1ps
module dglb_gate
  import dglb_pkg::*;
(
  input  logic     gate_a_n_i,
  input  logic     gate_b_n_i,
  input  logic     clr_i,
  output lb_mode_e mode_o
);
  logic both_low;

  always_comb begin
    both_low = ~(gate_a_n_i | gate_b_n_i);
    if (clr_i)         mode_o = LB_CLEAR;
    else if (both_low) mode_o = LB_OPEN;
    else               mode_o = LB_HOLD;
  end
endmodule

// File: rtl/dglb_cell.sv
`timescale 1ns/1ps
module dglb_cell
  import dglb_pkg::*;
(
  input  lb_mode_e mode_i,
  input  logic     d_i,
  output logic     q_o
);
  always_latch begin
    if (mode_i == LB_CLEAR)     q_o <= 1'b0;
    else if (mode_i == LB_OPEN) q_o <= d_i;
  end
endmodule

// File: rtl/dglb_outstage.sv
`timescale 1ns/1ps
module dglb_outstage #(
  parameter int unsigned WIDTH = 6
) (
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] qb_o
);
  always_comb begin
    q_o  = q_i;
    qb_o = ~q_i;
  end
endmodule

// File: rtl/dual_gate_latch_bank.sv
`timescale 1ns/1ps
module dual_gate_latch_bank
  import dglb_pkg::*;
#(
  parameter int unsigned WIDTH = DGLB_WIDTH
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             gate_a_n_i,
  input  logic             gate_b_n_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] qb_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  lb_mode_e         mode;
  logic [WIDTH-1:0] store;

  dglb_gate u_gate (
    .gate_a_n_i (gate_a_n_i),
    .gate_b_n_i (gate_b_n_i),
    .clr_i      (clr_i),
    .mode_o     (mode)
  );

  // one latch per bit, all on the shared mode (R1)
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    dglb_cell u_cell (
      .mode_i (mode),
      .d_i    (d_i[i]),
      .q_o    (store[i])
    );
  end

  dglb_outstage #(.WIDTH(WIDTH)) u_out (
    .q_i  (store),
    .q_o  (q_o),
    .qb_o (qb_o)
  );

  // deferred checks: evaluated once the time step has settled
  always_comb begin
    if (clr_i)
      assert_clear_zero_R5: assert final (q_o == '0);
    if (clr_i)
      assert_clear_comp_ones_R7: assert final (qb_o == ALL_ONES);
    if (!clr_i && !gate_a_n_i && !gate_b_n_i)
      assert_transparent_R2: assert final (q_o == d_i);
    assert_complement_R6: assert final ((q_o ^ qb_o) == ALL_ONES);
  end
endmodule

// File: tb/sim_dual_gate_latch_bank.sv
`timescale 1ns/1ps
module sim_dual_gate_latch_bank;
  localparam int W = 6;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] d;
  logic         ga, gb, clr;
  logic [W-1:0] q, qb;

  int tests = 0;
  int fails = 0;
  int viol  = 0;

  dual_gate_latch_bank #(.WIDTH(W)) u0 (
    .d_i(d), .gate_a_n_i(ga), .gate_b_n_i(gb), .clr_i(clr),
    .q_o(q), .qb_o(qb)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // timing monitor for the R8 and R10 usage rules
  wire    open_b = !ga && !gb;
  realtime t_d = -100.0, t_open = -100.0, t_close = -100.0;
  realtime t_crise = -100.0, t_cfall = -100.0;

  always @(d) begin
    if ($realtime > 0.5 && !open_b && !clr && ($realtime - t_close) < 0.4) viol++;
    t_d = $realtime;
  end
  always @(open_b) begin
    if ($realtime > 0.5) begin
      if (open_b) t_open = $realtime;
      else if (!clr) begin
        if (($realtime - t_d) < 1.0)     viol++;
        if (($realtime - t_open) < 2.0)  viol++;
        if (($realtime - t_cfall) < 1.6) viol++;
        t_close = $realtime;
      end
    end
  end
  always @(clr) begin
    if ($realtime > 0.5) begin
      if (clr) t_crise = $realtime;
      else begin
        if (($realtime - t_crise) < 2.0) viol++;
        t_cfall = $realtime;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] base;
    d = '0; ga = 1'b1; gb = 1'b1; clr = 1'b1;
    #3;
    chk("R5 reset q", q, '0);
    chk("R7 reset qb", qb, ONES);

    // clear overrides an open gate
    d = 6'h2A; #2;
    ga = 1'b0; gb = 1'b0; #2;
    chk("R5 clear over open gate", q, '0);
    clr = 1'b0; #2;
    chk("R9 release while open", q, 6'h2A);

    // exhaustive transparent sweep
    for (int v = 0; v < (1 << W); v++) begin
      d = v[W-1:0]; #2;
      chk("R2 transparent", q, v[W-1:0]);
      chk("R6 complement", qb, ~v[W-1:0]);
    end
    for (int i = 0; i < W; i++) begin
      d = W'(1) << i; #2;
      chk("R1 walking one", q, W'(1) << i);
    end

    // hold under each closing combination
    for (int k = 1; k < 4; k++) begin
      base = W'(k * 19);
      d = base; #2;
      ga = k[0]; gb = k[1]; #2;
      for (int v = 0; v < (1 << W); v++) begin
        d = v[W-1:0]; #2;
        chk("R3 hold ignores data", q, base);
      end
      chk("R6 complement held", qb, ~base);
      ga = 1'b0; gb = 1'b0; #2;
      chk("R2 reopen", q, ONES);
    end

    // first gate edge decides the captured value
    d = 6'h0C; #2;
    gb = 1'b1; #2;
    d = 6'h33; #2;
    ga = 1'b1; #2;
    chk("R4 second edge no recapture", q, 6'h0C);
    gb = 1'b0; #2;
    d = 6'h21; #2;
    chk("R4 one gate still high", q, 6'h0C);
    ga = 1'b0; #2;
    chk("R2 both low again", q, 6'h21);

    // capture window
    d = 6'h15; #1.2;
    ga = 1'b1; #0.5;
    d = 6'h2A; #1;
    chk("R8 late data ignored", q, 6'h15);
    ga = 1'b0; #2;
    chk("R2 reopen after window", q, 6'h2A);
    d = 6'h07; #1.2;
    gb = 1'b1; #1;
    chk("R8 setup data captured", q, 6'h07);
    gb = 1'b0; #2;

    // clear while held, release while closed
    d = ONES; #2;
    ga = 1'b1; #2;
    chk("R3 held ones", q, ONES);
    clr = 1'b1; #2;
    chk("R5 clear while held", q, '0);
    chk("R7 clear while held qb", qb, ONES);
    d = 6'h12; #1;
    chk("R5 data ignored in clear", q, '0);
    clr = 1'b0; #2;
    chk("R9 release while closed", q, '0);
    chk("R6 complement after release", qb, ONES);
    ga = 1'b0; #2;
    chk("R9 reopen follows data", q, 6'h12);

    // recovery: release, wait, then close
    clr = 1'b1; #2.5;
    clr = 1'b0; #2;
    d = 6'h2D; #2;
    gb = 1'b1; #2;
    d = 6'h00; #2;
    chk("R10 capture after recovery", q, 6'h2D);

    chk("R10 timing monitor violations", W'(viol), '0);
    summary();
    $finish;
  end
endmodule